// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between a bank of divided clocks and their output pads and decides, cycle by cycle in the fast reference-clock domain, which of those clocks may reach the pins. A low level on the asynchronous power-down request is brought into the reference domain and must persist before it is acted on. Each output then parks low at a moment when its own source clock is already low, so the last high phase is never cut short.

On release, a wake-delay counter holds every output parked for a programmable number of reference cycles. It models the bounded settling time the clock tree needs. After that, each output restarts only while its source is low, so its first high phase is full width. Independent of power-down, every output has a static enable bit that parks it low in the same glitch-free way. A global tristate bit drives the per-output pad-enable vector. A status flag reports when the bank is fully parked.

The divided clocks are generated from the reference clock. The block samples them on reference rising edges, and every gated output is a register that follows its source one reference cycle later.

Top module: `clk_pwr_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it, every clk_out bit is 0, every clk_oe bit is 0 and pwr_down is 0.
- R2: A low pd_n (0 = request) passes two synchroniser flops. The sequencer enters power-down only when the synchronised request is seen low on QUAL consecutive reference rising edges. Each output is gated from the edge after that.
- R3: If the synchronised request returns high before QUAL consecutive low samples, the count clears and no output is gated.
- R4: Outputs change only with their source. clk_out[i] falls only one cycle after div_clk[i] was sampled low, and rises only one cycle after div_clk[i] was sampled high, so no high phase is shortened.
- R5: pwr_down is 1 exactly while the sequencer is powered down and every output is parked. While it is 1, clk_out is all zeros.
- R6: After the synchronised request goes high, the outputs stay parked for WAKE_CYCLES+1 further reference cycles in the wake state. This state never lasts longer than that.
- R7: On wake, an output resumes only from a cycle in which its source is low. Its first rise on clk_out follows release of pd_n by between WAKE_CYCLES+6 and WAKE_CYCLES+8 reference edges for an output whose source toggles every cycle.
- R8: An output whose out_en bit is 0 (1 = enabled) parks low at its source's next low phase and stays low. Re-enabling it resumes it glitch-free.
- R9: clk_oe is all ones one cycle after tri_all is sampled 0, and all zeros one cycle after tri_all is sampled 1. A 0 bit means the pad is high impedance.
- R10: A request that reappears during the wake delay returns the sequencer straight to power-down without a new qualification. Outputs stay parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| div_clk | input | N_OUT | Divided source clocks, synchronous to ref_clk |
| out_en | input | N_OUT | Per-output enable, 1 = allowed to run |
| tri_all | input | 1 | 1 = all pads high impedance |
| clk_out | output | N_OUT | Gated clock outputs |
| clk_oe | output | N_OUT | Pad drive enables, 1 = drive |
| pwr_down | output | 1 | 1 = powered down with all outputs parked |

## Verification
The bench builds the block with four outputs whose sources toggle every 1, 2, 3 and 4 reference cycles, QUAL = 2 and WAKE_CYCLES = 6. The sources then reach the qualification edge in every phase. The slowest source needs up to four cycles to park, so the gap between qualification and a fully parked bank becomes visible. The short wake delay lets the release window, the full-width first pulse and a request reappearing in mid-wake all occur within a few dozen cycles.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_DOWN = 2'd1,
    PS_WAKE = 2'd2
  } pwr_state_t;

  // Next value of an output's run flag: it may change only while the source is low.
  function automatic logic run_step(input logic run, input logic go, input logic src);
    if (run) return go | src;
    return go & ~src;
  endfunction

  // Gated output value registered from the source and the next run flag.
  function automatic logic gated_value(input logic src, input logic run_nx);
    return src & run_nx;
  endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_n};
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import clk_pwr_pkg::*;
#(
  parameter int QUAL        = 2,
  parameter int WAKE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_n,
  output pwr_state_t state
);
  localparam int CW = (QUAL > 1) ? $clog2(QUAL) : 1;
  localparam int WW = $clog2(WAKE_CYCLES + 2);
  localparam logic [CW-1:0] QLAST = CW'(QUAL - 1);
  localparam logic [WW-1:0] WLOAD = WW'(WAKE_CYCLES);

  logic [CW-1:0] low_cnt;
  logic [WW-1:0] wake_cnt;
  logic          qual_hit;

  assign qual_hit = !req_n && (low_cnt == QLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      wake_cnt <= '0;
      state    <= PS_RUN;
    end else begin
      if (req_n)                low_cnt <= '0;
      else if (low_cnt != QLAST) low_cnt <= low_cnt + 1'b1;

      case (state)
        PS_RUN:  if (qual_hit) state <= PS_DOWN;
        PS_DOWN: if (req_n) begin
                   state    <= PS_WAKE;
                   wake_cnt <= WLOAD;
                 end
        PS_WAKE: begin
          if (!req_n)               state <= PS_DOWN;
          else if (wake_cnt == '0)  state <= PS_RUN;
          else                      wake_cnt <= wake_cnt - 1'b1;
        end
        default: state <= PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/out_gate.sv
module out_gate
  import clk_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic src,
  output logic run,
  output logic out
);
  logic run_nx;

  assign run_nx = run_step(run, go, src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      out <= 1'b0;
    end else begin
      run <= run_nx;
      out <= gated_value(src, run_nx);
    end
  end
endmodule

// File: rtl/clk_pwr_seq.sv
module clk_pwr_seq
  import clk_pwr_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int QUAL        = 2,
  parameter int WAKE_CYCLES = 8
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [N_OUT-1:0] div_clk,
  input  logic [N_OUT-1:0] out_en,
  input  logic             tri_all,
  output logic [N_OUT-1:0] clk_out,
  output logic [N_OUT-1:0] clk_oe,
  output logic             pwr_down
);
  logic       sync_n;
  pwr_state_t state;
  logic [N_OUT-1:0] go;
  logic [N_OUT-1:0] run;

  pd_sync #(.STAGES(2)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .async_n(pd_n), .sync_n(sync_n)
  );

  pd_ctrl #(.QUAL(QUAL), .WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(ref_clk), .rst_n(rst_n), .req_n(sync_n), .state(state)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign go[i] = (state == PS_RUN) && out_en[i];
    out_gate u_gate (
      .clk(ref_clk), .rst_n(rst_n), .go(go[i]), .src(div_clk[i]),
      .run(run[i]), .out(clk_out[i])
    );
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) clk_oe <= '0;
    else        clk_oe <= {N_OUT{~tri_all}};
  end

  assign pwr_down = (state == PS_DOWN) && (run == '0);
endmodule

// File: rtl/clk_pwr_seq_chk.sv
module clk_pwr_seq_chk
  import clk_pwr_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int QUAL        = 2,
  parameter int WAKE_CYCLES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_n,
  input pwr_state_t       state,
  input logic [N_OUT-1:0] run,
  input logic [N_OUT-1:0] div_clk,
  input logic [N_OUT-1:0] out_en,
  input logic [N_OUT-1:0] clk_out,
  input logic [N_OUT-1:0] clk_oe,
  input logic             tri_all,
  input logic             pwr_down
);
  localparam int LW = $clog2(QUAL + 2);
  localparam int KW = $clog2(WAKE_CYCLES + 3);

  logic [LW-1:0] low_seen;
  logic [KW-1:0] wake_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_seen  <= '0;
      wake_seen <= '0;
    end else begin
      if (sync_n) low_seen <= '0;
      else if (low_seen != LW'(QUAL)) low_seen <= low_seen + 1'b1;
      if (state == PS_WAKE) wake_seen <= wake_seen + 1'b1;
      else                  wake_seen <= '0;
    end
  end

  // R2
  qual_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_DOWN && $past(state) == PS_RUN) |-> (low_seen >= LW'(QUAL)));

  // R5
  parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (clk_out == '0));

  // R6
  wake_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAKE) |-> (wake_seen <= KW'(WAKE_CYCLES)));

  // R9
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (clk_oe == {N_OUT{~$past(tri_all)}}));

  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAKE && !sync_n) |=> (state == PS_DOWN));

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    // R4
    no_runt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_out[i]) |-> !$past(div_clk[i]));
    // R4
    no_runt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out[i]) |-> $past(div_clk[i]));
    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en[i] && !run[i]) |=> !clk_out[i]);
  end
endmodule

bind clk_pwr_seq clk_pwr_seq_chk #(
  .N_OUT(N_OUT), .QUAL(QUAL), .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
  .clk(ref_clk), .rst_n(rst_n), .sync_n(sync_n), .state(state), .run(run),
  .div_clk(div_clk), .out_en(out_en), .clk_out(clk_out), .clk_oe(clk_oe),
  .tri_all(tri_all), .pwr_down(pwr_down)
);

// File: tb/sim_clk_pwr_seq.sv
`timescale 1ns/1ps
module sim_clk_pwr_seq;
  localparam int N  = 4;
  localparam int QL = 2;
  localparam int WK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic [N-1:0] div_clk = '0;
  logic [N-1:0] out_en = '1;
  logic tri_all = 1'b0;
  logic [N-1:0] clk_out;
  logic [N-1:0] clk_oe;
  logic pwr_down;

  always #2 clk = ~clk;

  clk_pwr_seq #(.N_OUT(N), .QUAL(QL), .WAKE_CYCLES(WK)) u0 (
    .ref_clk(clk), .rst_n(rst_n), .pd_n(pd_n), .div_clk(div_clk),
    .out_en(out_en), .tri_all(tri_all), .clk_out(clk_out),
    .clk_oe(clk_oe), .pwr_down(pwr_down)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // Source clocks: output i flips every i+1 reference cycles.
  int phase [N];
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      phase[i] = phase[i] + 1;
      if (phase[i] >= i + 1) begin
        phase[i] = 0;
        div_clk[i] = ~div_clk[i];
      end
    end
  end

  // Behavioural reference: mode 0 running, 1 asleep, 2 waking.
  int m_s [$];
  int m_lows, m_mode, m_wait;
  bit m_on [N];
  logic [N-1:0] m_out, m_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = {1, 1};
      m_lows = 0; m_mode = 0; m_wait = 0;
      m_out = '0; m_oe = '0;
      foreach (m_on[i]) m_on[i] = 0;
    end else begin
      int req_hi, old_mode;
      req_hi = m_s[1];
      old_mode = m_mode;
      for (int i = 0; i < N; i++) begin
        bit allow;
        allow = (old_mode == 0) && out_en[i];
        // Switch on/off only while the source sits low.
        if (div_clk[i] == 1'b0) m_on[i] = allow;
        m_out[i] = div_clk[i] & m_on[i];
      end
      if (old_mode == 0) begin
        if (!req_hi && m_lows >= QL - 1) m_mode = 1;
      end else if (old_mode == 1) begin
        if (req_hi) begin m_mode = 2; m_wait = WK; end
      end else begin
        if (!req_hi) m_mode = 1;
        else if (m_wait == 0) m_mode = 0;
        else m_wait--;
      end
      if (req_hi) m_lows = 0;
      else if (m_lows < QL - 1) m_lows++;
      m_oe = tri_all ? '0 : '1;
      void'(m_s.pop_back());
      m_s.push_front(pd_n);
    end
  end

  function automatic bit m_parked();
    bit any = 0;
    foreach (m_on[i]) any |= m_on[i];
    return (m_mode == 1) && !any;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference.
  always @(negedge clk) begin
    if (!done) begin
      chk(clk_out === m_out, cur_req, "clk_out", clk_out, m_out);
      chk(clk_oe === m_oe, "R9", "clk_oe", clk_oe, m_oe);
      chk(pwr_down === m_parked(), cur_req, "pwr_down", pwr_down, m_parked());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    bit slept;
    int first_rise;
    cyc(4);
    chk(clk_out == '0 && clk_oe == '0 && pwr_down == 1'b0, "R1", "reset",
        {clk_out, clk_oe, pwr_down}, 0);
    rst_n = 1'b1;
    cyc(1);
    chk(clk_out == '0 && pwr_down == 1'b0, "R1", "first cycle", clk_out, 0);

    cur_req = "R4"; cyc(30);

    cur_req = "R9"; tri_all = 1'b1; cyc(2);
    chk(clk_oe == '0, "R9", "tristate", clk_oe, 0);
    tri_all = 1'b0; cyc(2);
    chk(clk_oe == '1, "R9", "drive", clk_oe, 4'hf);

    cur_req = "R8"; out_en = 4'b1101; cyc(20);
    chk(clk_out[1] == 1'b0, "R8", "disabled low", clk_out[1], 0);
    out_en = '1; cyc(10);

    cur_req = "R3"; slept = 0;
    pd_n = 1'b0; cyc(1); pd_n = 1'b1;
    for (int k = 0; k < 30; k++) begin cyc(1); if (pwr_down) slept = 1; end
    chk(!slept, "R3", "short request", slept, 0);

    cur_req = "R2"; pd_n = 1'b0; cyc(3);
    chk(pwr_down == 1'b0, "R2", "not yet qualified", pwr_down, 0);
    cur_req = "R5"; cyc(20);
    chk(pwr_down == 1'b1 && clk_out == '0, "R5", "parked", {pwr_down, clk_out}, 5'h10);

    cur_req = "R6"; pd_n = 1'b1; first_rise = 0;
    for (int k = 1; k <= WK + 12; k++) begin
      cyc(1);
      if (first_rise == 0 && clk_out[0]) first_rise = k;
      if (k == WK + 4) chk(clk_out == '0, "R6", "held during wake", clk_out, 0);
    end
    chk(first_rise >= WK + 6 && first_rise <= WK + 8, "R7", "first rise edge",
        first_rise, WK + 6);
    cur_req = "R7"; cyc(20);

    cur_req = "R10"; pd_n = 1'b0; cyc(20);
    pd_n = 1'b1; cyc(5);
    pd_n = 1'b0; cyc(6);
    chk(pwr_down == 1'b1 && clk_out == '0, "R10", "rearm in wake",
        {pwr_down, clk_out}, 5'h10);
    pd_n = 1'b1; cyc(WK + 20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule